// File: doc/BRIEF.md
# Load-Store Ordering and Forwarding Unit

This block holds the memory operations of an out-of-order core between issue and retirement, when that core has a single data-memory port. Each load or store gets an entry in a circular queue kept in program order. The entry holds an address field, the base operand, the store-data operand and the reorder-buffer tag. While the base operand is outstanding, the address field holds the instruction's immediate. It is replaced by the effective address (immediate plus base) when the operation enters execution.

Operations enter execution strictly in program order, one per cycle, so every store older than a load already has its final address when that load is considered.

- **Stores** need both operands before they enter execution. They spend one cycle there and present their address and data on a write-result port. They stay in the queue until the commit logic retires them.
- **Loads whose address matches an older pending store** take that store's data without touching memory. When several older stores match, the youngest one supplies the data.
- **All other loads** request the single memory unit. They report their result in the cycle after the memory answers.

Top module: `ldst_order_unit`

## Requirements
- R1: After reset the queue is empty: `iss_ready` is 1 and `mem_req`, `ld_valid` and `st_valid` are 0.
- R2: An issue is accepted on a clock edge where `iss_valid` and `iss_ready` are both high. `iss_ready` is low exactly when DEPTH entries are held, and an issue offered then is dropped.
- R3: The effective address of an operation is its immediate plus the low address bits of its base operand. It appears on `mem_addr` for a memory load and on `st_addr` for a store.
- R4: Operations enter execution in program order, at most one per cycle. No younger operation executes before an older one.
- R5: A store enters execution only when both its base and data operands are available. In the following cycle `st_valid` is 1, with its tag, address and data.
- R6: A load that has an older store still lacking an operand does not execute: it neither requests memory nor produces a result.
- R7: A load whose effective address equals the address of an older store still held in the queue takes that store's data. It raises `ld_valid` with `ld_fwd`=1 in the cycle after it executes, without raising `mem_req`.
- R8: When several older stores match a load's address, the data comes from the youngest of them.
- R9: A load with no matching older store raises `mem_req` with its address while the memory unit is idle. It executes on `mem_gnt`. No further request is made until `mem_rvalid`, and in the cycle after `mem_rvalid` the load result appears with `ld_fwd`=0 and the data from `mem_rdata`.
- R10: The result port carries one load per cycle. In a cycle where `mem_rvalid` is high, the memory result wins and a load that could be forwarded waits.
- R11: An operand waiting on a tag is captured when `wk_valid` broadcasts that tag, including in the cycle the operation is issued. The operation can execute in the next cycle.
- R12: Entries leave the queue from the oldest end only. A load leaves once its result has been produced; a store leaves on `st_retire` once it has executed. The freed place is available to issue in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_ready | output | 1 | Queue has a free entry |
| iss_is_st | input | 1 | 1 = store, 0 = load |
| iss_imm | input | 16 | Immediate offset |
| iss_base_rdy | input | 1 | Base operand value is valid |
| iss_base_tag | input | 4 | Producer tag of the base operand when not ready |
| iss_base_val | input | 32 | Base operand value |
| iss_sdat_rdy | input | 1 | Store-data operand is valid |
| iss_sdat_tag | input | 4 | Producer tag of the store data when not ready |
| iss_sdat_val | input | 32 | Store-data value |
| iss_rob | input | 5 | Reorder-buffer tag of the operation |
| wk_valid | input | 1 | Result broadcast valid |
| wk_tag | input | 4 | Tag of the broadcast result |
| wk_val | input | 32 | Broadcast value |
| mem_req | output | 1 | A load requests the memory unit |
| mem_addr | output | 16 | Address of the requesting load |
| mem_gnt | input | 1 | Memory unit accepts the request this cycle |
| mem_rvalid | input | 1 | Memory unit returns data |
| mem_rdata | input | 32 | Returned data |
| st_retire | input | 1 | Commit retires the oldest store |
| ld_valid | output | 1 | Load result valid |
| ld_rob | output | 5 | Reorder-buffer tag of the load |
| ld_data | output | 32 | Load value |
| ld_fwd | output | 1 | Value came from an older store |
| st_valid | output | 1 | Store write-result valid |
| st_rob | output | 5 | Reorder-buffer tag of the store |
| st_addr | output | 16 | Store effective address |
| st_data | output | 32 | Store data |

## Verification
`iss_ready`, `mem_req` and `mem_addr` are combinational on the queue state, so they are due in the same cycle as the state that causes them. A store result or a forwarded load result is due one cycle after the edge where the operation executes. A memory load result is due one cycle after `mem_rvalid`. A freed entry shows up on `iss_ready` one cycle after the removing edge. The bench compares all outputs at the falling edge against a queue-based model that is stepped once per cycle with the same inputs. Each registered expectation is therefore compared exactly one cycle after the edge that produces it, and each combinational one in the cycle its state exists.

// File: rtl/ldst_pkg.sv
`timescale 1ns/1ps
package ldst_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 32;
    parameter int TAG_W  = 4;
    parameter int ROB_W  = 5;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [ROB_W-1:0]  rob_t;

    // one source operand: value once rdy, producer tag before
    typedef struct packed {
        logic  rdy;
        tag_t  tag;
        data_t val;
    } opnd_t;

    // one queue slot
    typedef struct packed {
        logic  vld;
        logic  is_st;
        logic  agen;   // effective address written, operation executed
        logic  done;   // load result produced
        addr_t addr;   // immediate before execution, effective address after
        opnd_t base;
        opnd_t sdat;
        rob_t  rob;
    } lsq_ent_t;

    // capture a broadcast result into a waiting operand
    function automatic opnd_t opnd_snoop(input opnd_t o, input logic wv,
                                         input tag_t wt, input data_t wd);
        opnd_t r;
        r = o;
        if (!o.rdy && wv && (o.tag == wt)) begin
            r.rdy = 1'b1;
            r.val = wd;
        end
        return r;
    endfunction

    function automatic addr_t eff_addr(input addr_t imm, input data_t b);
        return imm + b[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/ldst_fwd_pick.sv
`timescale 1ns/1ps
// Youngest older store whose address equals the candidate load's address.
module ldst_fwd_pick
    import ldst_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  lsq_ent_t [DEPTH-1:0] ents,
    input  logic [PTR_W-1:0]     head,
    input  logic [PTR_W-1:0]     span,   // entries older than the candidate
    input  addr_t                ea,
    output logic                 hit,
    output data_t                data
);
    logic [PTR_W-1:0] idx;

    always_comb begin
        hit  = 1'b0;
        data = '0;
        idx  = '0;
        // walk oldest to youngest; a later match overrides an earlier one
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PTR_W'(k);
            if ((PTR_W'(k) < span) && ents[idx].vld && ents[idx].is_st &&
                (ents[idx].addr == ea)) begin
                hit  = 1'b1;
                data = ents[idx].sdat.val;
            end
        end
    end
endmodule

// File: rtl/ldst_mem_port.sv
`timescale 1ns/1ps
// Occupancy of the single unpipelined memory unit.
module ldst_mem_port
    import ldst_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PTR_W-1:0] start_idx,
    input  rob_t             start_rob,
    input  logic             mem_rvalid,
    output logic             busy,
    output logic             ret_fire,
    output logic [PTR_W-1:0] ret_idx,
    output rob_t             ret_rob
);
    assign ret_fire = busy && mem_rvalid;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            ret_idx <= '0;
            ret_rob <= '0;
        end else if (ret_fire) begin
            busy <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            ret_idx <= start_idx;
            ret_rob <= start_rob;
        end
    end
endmodule

// File: rtl/ldst_order_unit.sv
`timescale 1ns/1ps
// In-order address generation, store-to-load forwarding, single memory port.
// DEPTH must be a power of two.
module ldst_order_unit
    import ldst_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    iss_valid,
    output logic                    iss_ready,
    input  logic                    iss_is_st,
    input  logic [ADDR_W-1:0]       iss_imm,
    input  logic                    iss_base_rdy,
    input  logic [TAG_W-1:0]        iss_base_tag,
    input  logic [DATA_W-1:0]       iss_base_val,
    input  logic                    iss_sdat_rdy,
    input  logic [TAG_W-1:0]        iss_sdat_tag,
    input  logic [DATA_W-1:0]       iss_sdat_val,
    input  logic [ROB_W-1:0]        iss_rob,
    input  logic                    wk_valid,
    input  logic [TAG_W-1:0]        wk_tag,
    input  logic [DATA_W-1:0]       wk_val,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_gnt,
    input  logic                    mem_rvalid,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic                    st_retire,
    output logic                    ld_valid,
    output logic [ROB_W-1:0]        ld_rob,
    output logic [DATA_W-1:0]       ld_data,
    output logic                    ld_fwd,
    output logic                    st_valid,
    output logic [ROB_W-1:0]        st_rob,
    output logic [ADDR_W-1:0]       st_addr,
    output logic [DATA_W-1:0]       st_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    lsq_ent_t [DEPTH-1:0] ents;
    logic [PTR_W-1:0]     head, tail, agp;
    logic [CNT_W-1:0]     cnt;

    lsq_ent_t         cand, hd;
    logic             cand_live, fwd_hit;
    addr_t            cand_ea;
    data_t            fwd_data;
    logic             agen_st, agen_fwd, agen_mem, agen_any;
    logic             push, pop;
    logic             busy, ret_fire;
    logic [PTR_W-1:0] ret_idx;
    rob_t             ret_rob;
    opnd_t            new_base, new_sdat;

    // candidate: oldest operation not yet executed
    assign cand      = ents[agp];
    assign cand_ea   = eff_addr(cand.addr, cand.base.val);
    assign cand_live = cand.vld && !cand.agen && cand.base.rdy &&
                       (!cand.is_st || cand.sdat.rdy);

    ldst_fwd_pick #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_pick (
        .ents (ents),
        .head (head),
        .span (agp - head),
        .ea   (cand_ea),
        .hit  (fwd_hit),
        .data (fwd_data)
    );

    ldst_mem_port #(.PTR_W(PTR_W)) u_mport (
        .clk        (clk),
        .rst        (rst),
        .start      (agen_mem),
        .start_idx  (agp),
        .start_rob  (cand.rob),
        .mem_rvalid (mem_rvalid),
        .busy       (busy),
        .ret_fire   (ret_fire),
        .ret_idx    (ret_idx),
        .ret_rob    (ret_rob)
    );

    assign agen_st  = cand_live && cand.is_st;
    assign agen_fwd = cand_live && !cand.is_st && fwd_hit && !ret_fire;
    assign mem_req  = cand_live && !cand.is_st && !fwd_hit && !busy;
    assign mem_addr = cand_ea;
    assign agen_mem = mem_req && mem_gnt;
    assign agen_any = agen_st || agen_fwd || agen_mem;

    assign iss_ready = (cnt != CNT_W'(DEPTH));
    assign push      = iss_valid && iss_ready;
    assign hd        = ents[head];
    assign pop       = hd.vld && (hd.is_st ? (hd.agen && st_retire) : hd.done);

    assign new_base = opnd_snoop('{rdy: iss_base_rdy, tag: iss_base_tag, val: iss_base_val},
                                 wk_valid, wk_tag, wk_val);
    assign new_sdat = opnd_snoop('{rdy: iss_sdat_rdy, tag: iss_sdat_tag, val: iss_sdat_val},
                                 wk_valid, wk_tag, wk_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            ents     <= '0;
            head     <= '0;
            tail     <= '0;
            agp      <= '0;
            cnt      <= '0;
            ld_valid <= 1'b0;
            ld_rob   <= '0;
            ld_data  <= '0;
            ld_fwd   <= 1'b0;
            st_valid <= 1'b0;
            st_rob   <= '0;
            st_addr  <= '0;
            st_data  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                ents[i].base <= opnd_snoop(ents[i].base, wk_valid, wk_tag, wk_val);
                ents[i].sdat <= opnd_snoop(ents[i].sdat, wk_valid, wk_tag, wk_val);
            end
            if (agen_any) begin
                ents[agp].addr <= cand_ea;
                ents[agp].agen <= 1'b1;
                agp            <= agp + 1'b1;
            end
            if (agen_fwd) ents[agp].done <= 1'b1;
            if (ret_fire) ents[ret_idx].done <= 1'b1;
            if (pop) begin
                ents[head] <= '0;
                head       <= head + 1'b1;
            end
            if (push) begin
                ents[tail] <= '{vld: 1'b1, is_st: iss_is_st, agen: 1'b0, done: 1'b0,
                                addr: iss_imm, base: new_base, sdat: new_sdat, rob: iss_rob};
                tail       <= tail + 1'b1;
            end
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;

            // write-result registers
            ld_valid <= agen_fwd || ret_fire;
            ld_fwd   <= agen_fwd;
            ld_rob   <= ret_fire ? ret_rob : cand.rob;
            ld_data  <= ret_fire ? mem_rdata : fwd_data;
            st_valid <= agen_st;
            st_rob   <= cand.rob;
            st_addr  <= cand_ea;
            st_data  <= cand.sdat.val;
        end
    end
endmodule

// File: rtl/ldst_order_chk.sv
`timescale 1ns/1ps
module ldst_order_chk (
    input logic clk,
    input logic rst,
    input logic mem_req,
    input logic mem_gnt,
    input logic mem_rvalid,
    input logic ld_valid,
    input logic ld_fwd,
    input logic st_valid
);
    // R9
    mem_single_out_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt) |=> !mem_req);

    // R9
    mem_result_src_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_fwd) |-> $past(mem_rvalid));

    // R10
    fwd_port_free_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_fwd) |-> !$past(mem_rvalid));

    // R4
    one_exec_chk: assert property (@(posedge clk) disable iff (rst)
        !(st_valid && ld_valid && ld_fwd));
endmodule

bind ldst_order_unit ldst_order_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .ld_valid   (ld_valid),
    .ld_fwd     (ld_fwd),
    .st_valid   (st_valid)
);

// File: tb/ldst_order_unit_tb.sv
`timescale 1ns/1ps
module ldst_order_unit_tb;
    localparam int DEPTH  = 8;
    localparam int MLAT   = 3;
    localparam int NCYC   = 4000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst;
    logic iss_valid, iss_ready, iss_is_st;
    logic [15:0] iss_imm;
    logic iss_base_rdy, iss_sdat_rdy;
    logic [3:0] iss_base_tag, iss_sdat_tag;
    logic [31:0] iss_base_val, iss_sdat_val;
    logic [4:0] iss_rob;
    logic wk_valid;
    logic [3:0] wk_tag;
    logic [31:0] wk_val;
    logic mem_req, mem_gnt, mem_rvalid;
    logic [15:0] mem_addr;
    logic [31:0] mem_rdata;
    logic st_retire;
    logic ld_valid, ld_fwd, st_valid;
    logic [4:0] ld_rob, st_rob;
    logic [31:0] ld_data, st_data;
    logic [15:0] st_addr;

    ldst_order_unit #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_is_st(iss_is_st),
        .iss_imm(iss_imm), .iss_base_rdy(iss_base_rdy), .iss_base_tag(iss_base_tag),
        .iss_base_val(iss_base_val), .iss_sdat_rdy(iss_sdat_rdy),
        .iss_sdat_tag(iss_sdat_tag), .iss_sdat_val(iss_sdat_val), .iss_rob(iss_rob),
        .wk_valid(wk_valid), .wk_tag(wk_tag), .wk_val(wk_val),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .st_retire(st_retire),
        .ld_valid(ld_valid), .ld_rob(ld_rob), .ld_data(ld_data), .ld_fwd(ld_fwd),
        .st_valid(st_valid), .st_rob(st_rob), .st_addr(st_addr), .st_data(st_data)
    );

    // ---------------- behavioural model ----------------
    typedef struct {
        bit          st;
        int          addr;
        bit          agen;
        bit          done;
        bit          brdy;
        int          btag;
        logic [31:0] bval;
        bit          drdy;
        int          dtag;
        logic [31:0] dval;
        int          rob;
    } ment_t;

    ment_t q[$];
    bit          m_busy;
    int          m_brob;
    int          mem_cnt;
    logic [31:0] mem_pend;
    bit          e_ldv, e_ldf, e_stv;
    int          e_ldrob, e_strob, e_sta;
    logic [31:0] e_ldd, e_std;
    string       t_ld, t_st, t_iss;
    bit          first;
    int          n_chk, n_bad, rob_seq;
    int unsigned rng;

    function automatic int unsigned rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // candidate view of the model
    task automatic m_view(output int ci, output bit elig, output bit is_st, output int ea,
                          output bit hit, output bit multi, output logic [31:0] fd);
        int nm;
        ci = -1; elig = 0; is_st = 0; ea = 0; hit = 0; multi = 0; fd = '0; nm = 0;
        for (int i = 0; i < q.size(); i++) begin
            if (!q[i].agen) begin ci = i; break; end
        end
        if (ci >= 0) begin
            is_st = q[ci].st;
            elig  = q[ci].brdy && (!q[ci].st || q[ci].drdy);
            ea    = (q[ci].addr + int'(q[ci].bval[15:0])) & 32'hFFFF;
            for (int j = 0; j < ci; j++) begin
                if (q[j].st && q[j].addr == ea) begin nm++; fd = q[j].dval; end
            end
            hit   = (nm > 0);
            multi = (nm > 1);
        end
    endtask

    function automatic bit load_after(input int ci);
        for (int i = ci + 1; i < q.size(); i++) if (!q[i].st) return 1;
        return 0;
    endfunction

    task automatic compare();
        int ci, ea; bit elig, is_st, hit, multi, exp_req; logic [31:0] fd;
        string rt;
        m_view(ci, elig, is_st, ea, hit, multi, fd);
        exp_req = (ci >= 0) && elig && !is_st && !hit && !m_busy;
        if (first) rt = "R1";
        else if (ci >= 0 && is_st && !elig && load_after(ci)) rt = "R6";
        else rt = "R9";
        chk(iss_ready === (q.size() < DEPTH), first ? "R1" : t_iss, "iss_ready",
            32'(iss_ready), 32'(q.size() < DEPTH));
        chk(mem_req === exp_req, rt, "mem_req", 32'(mem_req), 32'(exp_req));
        if (exp_req) chk(mem_addr === 16'(ea), "R3", "mem_addr", 32'(mem_addr), 32'(ea));
        chk(ld_valid === e_ldv, t_ld, "ld_valid", 32'(ld_valid), 32'(e_ldv));
        if (e_ldv) begin
            chk(ld_fwd === e_ldf, t_ld, "ld_fwd", 32'(ld_fwd), 32'(e_ldf));
            chk(ld_rob === 5'(e_ldrob), t_ld, "ld_rob", 32'(ld_rob), 32'(e_ldrob));
            chk(ld_data === e_ldd, t_ld, "ld_data", ld_data, e_ldd);
        end
        chk(st_valid === e_stv, t_st, "st_valid", 32'(st_valid), 32'(e_stv));
        if (e_stv) begin
            chk(st_rob === 5'(e_strob), "R4", "st_rob", 32'(st_rob), 32'(e_strob));
            chk(st_addr === 16'(e_sta), "R3", "st_addr", 32'(st_addr), 32'(e_sta));
            chk(st_data === e_std, "R5", "st_data", st_data, e_std);
        end
        first = 0;
    endtask

    task automatic drive();
        bit rv;
        rv = 0;
        if (mem_cnt > 0) begin
            mem_cnt--;
            if (mem_cnt == 0) rv = 1;
        end
        mem_rvalid   = rv;
        mem_rdata    = mem_pend;
        mem_gnt      = (rnd() % 10) < 7;
        st_retire    = rnd() % 2;
        wk_valid     = (rnd() % 10) < 4;
        wk_tag       = 4'(1 + rnd() % 7);
        wk_val       = 32'(4 * (rnd() % 2));
        iss_valid    = (rnd() % 10) < 6;
        iss_is_st    = rnd() % 2;
        iss_imm      = 16'(4 * (rnd() % 4));
        iss_base_rdy = (rnd() % 3) != 0;
        iss_base_tag = 4'(1 + rnd() % 7);
        iss_base_val = iss_base_rdy ? 32'(4 * (rnd() % 2)) : 32'h0;
        iss_sdat_rdy = rnd() % 2;
        iss_sdat_tag = 4'(1 + rnd() % 7);
        iss_sdat_val = rnd();
        iss_rob      = 5'(rob_seq);
    endtask

    task automatic step();
        int ci, ea; bit elig, is_st, hit, multi, ret, a_st, a_fwd, req, a_mem, pop, push;
        logic [31:0] fd;
        ment_t n;
        m_view(ci, elig, is_st, ea, hit, multi, fd);
        ret   = m_busy && mem_rvalid;
        a_st  = (ci >= 0) && elig && is_st;
        a_fwd = (ci >= 0) && elig && !is_st && hit && !ret;
        req   = (ci >= 0) && elig && !is_st && !hit && !m_busy;
        a_mem = req && mem_gnt;
        pop   = (q.size() > 0) && (q[0].st ? (q[0].agen && st_retire) : q[0].done);
        push  = iss_valid && (q.size() < DEPTH);

        e_ldv   = a_fwd || ret;
        e_ldf   = a_fwd;
        e_ldrob = ret ? m_brob : ((ci >= 0) ? q[ci].rob : 0);
        e_ldd   = ret ? mem_rdata : fd;
        if (ret) t_ld = ((ci >= 0) && elig && !is_st && hit) ? "R10" : "R9";
        else if (a_fwd) t_ld = multi ? "R8" : "R7";
        else t_ld = "R4";
        e_stv   = a_st;
        e_strob = (ci >= 0) ? q[ci].rob : 0;
        e_sta   = ea;
        e_std   = (ci >= 0) ? q[ci].dval : '0;
        t_st    = a_st ? "R5" : ((ci >= 0 && is_st && !elig) ? "R11" : "R4");
        t_iss   = pop ? "R12" : "R2";

        for (int i = 0; i < q.size(); i++) begin
            if (wk_valid && !q[i].brdy && q[i].btag == int'(wk_tag)) begin
                q[i].brdy = 1; q[i].bval = wk_val;
            end
            if (wk_valid && !q[i].drdy && q[i].dtag == int'(wk_tag)) begin
                q[i].drdy = 1; q[i].dval = wk_val;
            end
        end
        if (a_st || a_fwd || a_mem) begin
            q[ci].addr = ea;
            q[ci].agen = 1;
            if (a_fwd) q[ci].done = 1;
        end
        if (ret) begin
            for (int i = 0; i < q.size(); i++) if (q[i].rob == m_brob) q[i].done = 1;
            m_busy = 0;
        end
        if (a_mem) begin
            m_busy   = 1;
            m_brob   = q[ci].rob;
            mem_cnt  = MLAT;
            mem_pend = 32'(ea * 7 + 32'h100);
        end
        if (pop) void'(q.pop_front());
        if (push) begin
            n.st   = iss_is_st;
            n.addr = int'(iss_imm);
            n.agen = 0;
            n.done = 0;
            n.brdy = iss_base_rdy; n.btag = int'(iss_base_tag); n.bval = iss_base_val;
            n.drdy = iss_sdat_rdy; n.dtag = int'(iss_sdat_tag); n.dval = iss_sdat_val;
            if (wk_valid && !n.brdy && n.btag == int'(wk_tag)) begin n.brdy = 1; n.bval = wk_val; end
            if (wk_valid && !n.drdy && n.dtag == int'(wk_tag)) begin n.drdy = 1; n.dval = wk_val; end
            n.rob  = rob_seq;
            q.push_back(n);
            rob_seq = (rob_seq + 1) % 32;
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        rng = 32'h1234_5678;
        n_chk = 0; n_bad = 0; rob_seq = 0;
        m_busy = 0; m_brob = 0; mem_cnt = 0; mem_pend = '0;
        e_ldv = 0; e_ldf = 0; e_stv = 0; e_ldrob = 0; e_strob = 0; e_sta = 0;
        e_ldd = '0; e_std = '0;
        t_ld = "R1"; t_st = "R1"; t_iss = "R1"; first = 1;
        rst = 1;
        iss_valid = 0; iss_is_st = 0; iss_imm = '0; iss_base_rdy = 0; iss_base_tag = '0;
        iss_base_val = '0; iss_sdat_rdy = 0; iss_sdat_tag = '0; iss_sdat_val = '0;
        iss_rob = '0; wk_valid = 0; wk_tag = '0; wk_val = '0;
        mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0; st_retire = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        for (int c = 0; c < NCYC; c++) begin
            if (c > 0) @(negedge clk);
            compare();
            drive();
            step();
        end
        @(negedge clk);
        compare();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog run did not end actual=0 expected=1");
        finish_run();
    end
endmodule